// File: doc/BRIEF.md
# Serial EEPROM Word Reader

After reset this block reads the full contents of a 64-word, 16-bit serial EEPROM over a three-wire interface. The interface has four signals: a chip select, a serial clock, data into the part and data out of the part. For each word the block raises chip select and clocks out a start bit, the two-bit read opcode and a six-bit word address. It then clocks in sixteen data bits. The words go into an internal image that a synchronous read port serves.

When the last word has arrived, the block adds all 64 words with 16-bit wraparound and compares the sum with a fixed signature. A mismatch raises an error flag. The 48-bit station address is unpacked from the first three words. Each serial clock phase, high or low, lasts `PHASE_CYCLES` system clocks. At the default of 250 this gives 1 µs per phase on a 250 MHz clock.

Top module: `ee_word_reader`

## Requirements
- R1: While `rst_n` is low, `ee_cs`, `ee_sk`, `ee_di`, `done` and `csum_err` are all low. The read sequence starts by itself when reset is released, with no other input.
- R2: Every serial clock phase, high or low, lasts exactly `PHASE_CYCLES` system clocks, and `ee_sk` is high only while `ee_cs` is high.
- R3: Each word transaction takes 52 phases in this order: one deselect phase (chip select low), one select phase (chip select high, clock low, data-in low), then 25 clock periods, each a low phase followed by a high phase.
- R4: During the 25 clock periods, `ee_di` carries 1 (start bit), then 1 and 0 (read opcode), then the six address bits, MSB first. It is low for the remaining 16 periods.
- R5: `ee_di` changes only at the start of a low phase and stays constant through every high phase.
- R6: One data bit is taken from `ee_do` in the last system clock of each high phase of periods 10 to 25. The first bit taken is the word's MSB.
- R7: Words are read at addresses 0 to 63 in ascending order. Chip select falls with the clock low, both between words and after the last word.
- R8: `csum_err` is high exactly when the 16-bit wrapping sum of all 64 words differs from 0xBABA. It is never high while `done` is low.
- R9: `done` rises 64 × 52 × `PHASE_CYCLES` clocks after reset release and stays high until the next reset. While it is high, all three interface outputs are low.
- R10: `rd_data` is a registered copy of image word `rd_addr`, with one clock of latency. A word written on the final sampling edge is returned on the clock after that edge.
- R11: `station_addr[8j+7:8j]` holds address byte j. Byte 2i is the low byte of word i and byte 2i+1 is its high byte, for i = 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| rd_addr | input | 6 | Image read address |
| rd_data | output | 16 | Image word, one clock after the address |
| station_addr | output | 48 | Station address, byte 0 in the low bits |
| done | output | 1 | Whole image read and checksum evaluated |
| csum_err | output | 1 | Sum of the words differs from the signature |

## Verification
On one clock edge the last data bit of word 63 is sampled, that word is written into the image, the checksum is settled and `done` rises. On that same edge the read port also registers its output. The bench holds `rd_addr` at 63 for the whole run, so the read port and the image write fall on one edge. It expects `done` high with the word from the previous run still on `rd_data`, then the new word 63 one clock later. A behavioural timeline computed from the count of clocks since reset is compared with the interface outputs on every clock. A second run uses a corrupted image and must raise `csum_err` on the same edge as `done`.

// File: rtl/ee_word_reader.sv
module ee_word_reader #(
  parameter int PHASE_CYCLES = 250,
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  ee_sk,
  output logic                  ee_cs,
  output logic                  ee_di,
  input  logic                  ee_do,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [WORD_W-1:0]     rd_data,
  output logic [3*WORD_W-1:0]   station_addr,
  output logic                  done,
  output logic                  csum_err
);

  localparam int NWORDS = 1 << ADDR_W;
  localparam int NCMD   = 3 + ADDR_W;
  localparam int NBITS  = NCMD + WORD_W;
  localparam int CW     = $clog2(PHASE_CYCLES + 1);
  localparam int BW     = $clog2(NBITS + 1);
  localparam logic [CW-1:0]     PH_LAST   = CW'(PHASE_CYCLES - 1);
  localparam logic [BW-1:0]     BIT_LAST  = BW'(NBITS - 1);
  localparam logic [BW-1:0]     CMD_N     = BW'(NCMD);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  typedef enum logic [2:0] {S_GAP, S_SEL, S_LO, S_HI, S_DONE} st_t;

  st_t                st;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bitk;
  logic [ADDR_W-1:0]  addr;
  logic [WORD_W-1:0]  shreg, sum;
  logic [WORD_W-1:0]  mem [NWORDS];

  wire              phase_end = (cnt == PH_LAST);
  wire [WORD_W-1:0] word_in   = {shreg[WORD_W-2:0], ee_do};
  wire              last_bit  = (st == S_HI) && phase_end && (bitk == BIT_LAST);
  wire [NCMD-1:0]   cmd       = {3'b110, addr};
  wire [NCMD-1:0]   cmd_sh    = cmd << bitk;
  wire              in_bits   = (st == S_LO) || (st == S_HI);

  assign ee_cs = in_bits || (st == S_SEL);
  assign ee_sk = (st == S_HI);
  assign ee_di = in_bits && (bitk < CMD_N) && cmd_sh[NCMD-1];
  assign done  = (st == S_DONE);
  assign station_addr = {mem[2], mem[1], mem[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_GAP;
      cnt      <= '0;
      bitk     <= '0;
      addr     <= '0;
      shreg    <= '0;
      sum      <= '0;
      csum_err <= 1'b0;
    end else if (st != S_DONE) begin
      cnt <= phase_end ? '0 : cnt + 1'b1;
      if (phase_end) begin
        case (st)
          S_GAP: st <= S_SEL;
          S_SEL: begin
            st   <= S_LO;
            bitk <= '0;
          end
          S_LO: st <= S_HI;
          S_HI: begin
            if (bitk >= CMD_N) shreg <= word_in;
            if (bitk == BIT_LAST) begin
              sum  <= sum + word_in;
              addr <= addr + 1'b1;
              if (addr == ADDR_LAST) begin
                st       <= S_DONE;
                csum_err <= (sum + word_in) != SIGNATURE;
              end else begin
                st <= S_GAP;
              end
            end else begin
              st   <= S_LO;
              bitk <= bitk + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (last_bit) mem[addr] <= word_in;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/ee_word_reader_chk.sv
module ee_word_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic ee_sk,
  input logic ee_cs,
  input logic ee_di,
  input logic done,
  input logic csum_err
);

  p_sk_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  p_di_steady_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  p_select_clock_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (!ee_sk && !ee_di));

  p_deselect_clock_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> !ee_sk);

  p_err_only_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err |-> done);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_done_bus_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_cs && !ee_sk && !ee_di));

endmodule

bind ee_word_reader ee_word_reader_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ee_sk    (ee_sk),
  .ee_cs    (ee_cs),
  .ee_di    (ee_di),
  .done     (done),
  .csum_err (csum_err)
);

// File: tb/test_ee_word_reader.sv
`timescale 1ns/1ps
module test_ee_word_reader;
  localparam int PH = 3;
  localparam int L  = 52 * PH;
  localparam int T_DONE = 64 * L;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ee_sk, ee_cs, ee_di;
  logic        ee_do = 1'b0;
  logic [5:0]  rd_addr = 6'd63;
  logic [15:0] rd_data;
  logic [47:0] station_addr;
  logic        done, csum_err;

  int vectors = 0;
  int miscompares = 0;

  logic [15:0] rom [64];
  logic [15:0] prev63;
  logic        have_prev = 1'b0;

  always #2 clk = ~clk;

  ee_word_reader #(.PHASE_CYCLES(PH)) i_ee_word_reader (
    .clk(clk), .rst_n(rst_n), .ee_sk(ee_sk), .ee_cs(ee_cs), .ee_di(ee_di),
    .ee_do(ee_do), .rd_addr(rd_addr), .rd_data(rd_data),
    .station_addr(station_addr), .done(done), .csum_err(csum_err));

  int       eek = 0;
  logic [5:0] eea = '0;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      eek = 0;
      ee_do = 1'b0;
    end else begin
      if (eek >= 3 && eek <= 8) eea = {eea[4:0], ee_di};
      if (eek >= 9 && eek <= 24) ee_do = rom[eea][24 - eek];
      eek++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic run(input int seed, input logic corrupt);
    logic [15:0] s;
    s = 16'h0;
    for (int i = 0; i < 63; i++) begin
      rom[i] = 16'(i * (16'h0123 + seed)) ^ 16'h5A3C ^ 16'(seed << 4);
      s = s + rom[i];
    end
    rom[63] = 16'hBABA - s;
    if (corrupt) rom[17] = rom[17] ^ 16'h0040;
    s = 16'h0;
    for (int i = 0; i < 64; i++) s = s + rom[i];

    rd_addr = 6'd63;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 cs in reset", ee_cs, 0);
    chk("R1 sk in reset", ee_sk, 0);
    chk("R1 di in reset", ee_di, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 csum_err in reset", csum_err, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int t = 0; t <= T_DONE + 1; t++) begin
      int w, p, k;
      logic ecs, esk, edi, edone;
      logic [8:0] cmd;
      w = t / L; p = (t % L) / PH;
      ecs = 0; esk = 0; edi = 0; edone = 0;
      if (w >= 64) edone = 1;
      else if (p == 1) ecs = 1;
      else if (p >= 2) begin
        k = (p - 2) / 2;
        ecs = 1;
        esk = ((p - 2) % 2) == 1;
        cmd = {3'b110, 6'(w)};
        edi = (k < 9) ? cmd[8 - k] : 1'b0;
      end
      chk("R3 cs timeline", ee_cs, ecs);
      chk("R2 sk timeline", ee_sk, esk);
      chk("R4 di timeline", ee_di, edi);
      chk("R9 done timing", done, edone);
      if (t == T_DONE) begin
        chk("R8 csum_err with done", csum_err, (s != 16'hBABA));
        if (have_prev) chk("R10 read before write visible", rd_data, prev63);
      end
      if (t == T_DONE + 1) chk("R10 last word next cycle", rd_data, rom[63]);
      @(negedge clk);
    end

    chk("R9 done held", done, 1);
    chk("R8 csum_err settled", csum_err, (s != 16'hBABA));
    chk("R11 station address", station_addr, {rom[2], rom[1], rom[0]});
    chk("R11 byte 0", station_addr[7:0], rom[0][7:0]);
    chk("R11 byte 5", station_addr[47:40], rom[2][15:8]);
    for (int a = 0; a < 64; a++) begin
      rd_addr = 6'(a);
      @(negedge clk);
      chk("R6 R7 image word", rd_data, rom[a]);
    end
    chk("R9 bus idle after done", {ee_cs, ee_sk, ee_di}, 3'b000);
    prev63 = rom[63];
    have_prev = 1'b1;
  endtask

  initial begin
    run(1, 1'b0);
    run(7, 1'b1);
    summary();
    $finish;
  end
endmodule